// File: doc/BRIEF.md
# BCD Calendar Counter With Divider Reset

This block is the timekeeping core of a real-time clock. It keeps seconds, minutes, hours, day of week, date, month and year as BCD registers. A prescaler divides a 32.768 kHz enable into a one-second tick, and the tick ripples through the cascaded counters in a single clock cycle. The date counter knows the length of every month, including February in leap years.

A bus front end, which is outside this block, writes any register through a simple write port and reads it back through a combinational read port. A write to the seconds register also clears the sub-second prescaler, so the next second starts a full period after the write. An oscillator-stop flag records a fail condition reported from outside. Software may clear the flag but can never set it.

Top module: `rtc_calendar_core`

## Requirements
- R1: After rst_ni is released, seconds, minutes, hours and year read 0x00, day of week, date and month read 0x01, and the flag register (address 7) reads 0x80.
- R2: The seconds register advances by one on the clock edge that sees the PRESCALE-th assertion of tick_32k_i since the last reset or seconds write. Clock cycles with tick_32k_i low do not count.
- R3: Seconds and minutes count 0x00..0x59 and hours count 0x00..0x23 in BCD. Each wraps to 0x00 and carries into the next counter in the same cycle.
- R4: Day of week counts 0x01..0x07, wraps to 0x01, and advances on every hour rollover (midnight).
- R5: The date wraps to 0x01 and carries into the month after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months.
- R6: February ends at 0x29 when the BCD year is divisible by 4, and at 0x28 otherwise.
- R7: Month wraps from 0x12 to 0x01 and carries into the year, and the year wraps from 0x99 to 0x00.
- R8: Any write to the seconds register (address 0) clears the prescaler. The next second then needs a full PRESCALE enables.
- R9: A write to a counter in the same cycle as its increment wins. A counter that is written emits no carry in that cycle.
- R10: The oscillator-stop flag (bit 7 of address 7) is set by osc_fail_i. A write with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it unchanged. osc_fail_i wins over a clearing write in the same cycle.
- R11: Bits outside each field read 0 and ignore writes. The field widths are seconds 7, minutes 7, hours 6, day of week 3, date 6, month 5 and year 8 bits, and flag bits 6..0 are always 0.
- R12: The map is seconds 0, minutes 1, hours 2, day of week 3, date 4, month 5, year 6 and flag 7. Addresses 8..15 read 0x00 and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_32k_i | input | 1 | One-cycle enable at 32.768 kHz |
| osc_fail_i | input | 1 | Oscillator failure indication, sets the stop flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write register address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read register address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |

## Verification
The checker watches several rules on every cycle:
- the flag is set after osc_fail_i, and software never sets it;
- the prescaler is cleared after a seconds write;
- seconds move only on a tick or a write;
- padding bits of the flag read as 0;
- unmapped addresses read as 0.

The month-length, leap-year and year-wrap rules, the midnight advance of the day of week, and write-over-carry priority depend on particular register contents. Only the bench scenarios show them, by loading edge dates and stepping the enable.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_FIELDS = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int FLAG_IDX = 7;
  localparam int OSF_BIT  = 7;

  typedef logic [DATA_W-1:0] bcd_t;

  function automatic bcd_t field_mask(input int i);
    case (i)
      F_SEC, F_MIN: return 8'h7f;
      F_HOUR, F_DATE: return 8'h3f;
      F_DOW: return 8'h07;
      F_MON: return 8'h1f;
      default: return 8'hff;
    endcase
  endfunction

  function automatic bcd_t field_min(input int i);
    case (i)
      F_DOW, F_DATE, F_MON: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bcd_t field_limit(input int i);
    case (i)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR: return 8'h23;
      F_DOW: return 8'h07;
      F_DATE: return 8'h31;
      F_MON: return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // BCD year divisible by 4: even tens -> ones 0/4/8, odd tens -> ones 2/6
  function automatic logic is_leap(input bcd_t y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic bcd_t month_days(input bcd_t m, input logic leap);
    case (m)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV   = 32768,
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o,
  output logic zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last   = (cnt_q == CNT_W'(DIV - 1));
  assign tick_o = en_i && last && !clr_i;
  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_cal_pkg::*;
#(
  parameter bcd_t MASK = 8'hff,
  parameter bcd_t MIN  = 8'h00
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  bcd_t lim_i,
  input  logic wr_i,
  input  bcd_t wr_data_i,
  output bcd_t val_o,
  output logic carry_o
);
  bcd_t val_q, nxt;
  logic at_lim;

  // >= so an out-of-range written value still wraps
  assign at_lim  = (val_q >= lim_i);
  assign nxt     = at_lim ? MIN : (bcd_inc(val_q) & MASK);
  assign carry_o = inc_i && at_lim && !wr_i;
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= MIN;
    else if (wr_i)   val_q <= wr_data_i & MASK;
    else if (inc_i)  val_q <= nxt;
  end
endmodule

// File: rtl/rtc_osf_flag.sv
module rtc_osf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  output logic osf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  osf_o <= 1'b1;
    else if (fail_i)              osf_o <= 1'b1;
    else if (wr_i && !wr_bit_i)   osf_o <= 1'b0;
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int PRESCALE = 32768,
  parameter int ADDR_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_32k_i,
  input  logic              osc_fail_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int SEL_W = $clog2(NUM_FIELDS);

  bcd_t                  fld_val [NUM_FIELDS];
  bcd_t                  fld_lim [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fld_inc, fld_wr, fld_carry;
  logic                  sec_tick, pre_at_zero, osf_q, flag_wr;
  logic                  unused_carry;

  rtc_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_32k_i),
    .clr_i  (fld_wr[F_SEC]),
    .tick_o (sec_tick),
    .zero_o (pre_at_zero)
  );

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    assign fld_wr[g] = wr_en_i && (wr_addr_i == ADDR_W'(g));
    rtc_bcd_field #(.MASK(field_mask(g)), .MIN(field_min(g))) u_fld (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (fld_inc[g]),
      .lim_i     (fld_lim[g]),
      .wr_i      (fld_wr[g]),
      .wr_data_i (wr_data_i),
      .val_o     (fld_val[g]),
      .carry_o   (fld_carry[g])
    );
  end

  always_comb begin
    fld_inc[F_SEC]  = sec_tick;
    fld_inc[F_MIN]  = fld_carry[F_SEC];
    fld_inc[F_HOUR] = fld_carry[F_MIN];
    fld_inc[F_DOW]  = fld_carry[F_HOUR];
    fld_inc[F_DATE] = fld_carry[F_HOUR];
    fld_inc[F_MON]  = fld_carry[F_DATE];
    fld_inc[F_YEAR] = fld_carry[F_MON];
  end

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) fld_lim[i] = field_limit(i);
    fld_lim[F_DATE] = month_days(fld_val[F_MON], is_leap(fld_val[F_YEAR]));
  end

  assign unused_carry = fld_carry[F_DOW] ^ fld_carry[F_YEAR];

  assign flag_wr = wr_en_i && (wr_addr_i == ADDR_W'(FLAG_IDX));

  rtc_osf_flag u_osf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fail_i   (osc_fail_i),
    .wr_i     (flag_wr),
    .wr_bit_i (wr_data_i[OSF_BIT]),
    .osf_o    (osf_q)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < ADDR_W'(NUM_FIELDS))
      rd_data_o = fld_val[rd_addr_i[SEL_W-1:0]];
    else if (rd_addr_i == ADDR_W'(FLAG_IDX))
      rd_data_o[OSF_BIT] = osf_q;
  end
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              osc_fail_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [7:0]        rd_data_o,
  input logic              osf_q,
  input logic              sec_tick,
  input logic              pre_at_zero,
  input logic [7:0]        sec_val
);
  logic wr_sec;
  assign wr_sec = wr_en_i && (wr_addr_i == '0);

  p_osf_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_fail_i |=> osf_q);

  p_osf_no_sw_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osf_q && !osc_fail_i) |=> !osf_q);

  p_div_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sec |=> pre_at_zero);

  p_sec_only_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_sec && !sec_tick) |=> $stable(sec_val));

  p_flag_pad_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == ADDR_W'(7)) |-> (rd_data_o[6:0] == 7'd0));

  p_hole_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i >= ADDR_W'(8)) |-> (rd_data_o == 8'd0));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .osc_fail_i  (osc_fail_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .osf_q       (osf_q),
  .sec_tick    (sec_tick),
  .pre_at_zero (pre_at_zero),
  .sec_val     (fld_val[0])
);

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
  localparam int CLK_PERIOD = 20;
  localparam int DIV        = 4;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       fail = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc_calendar_core #(.PRESCALE(DIV)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_32k_i (tick),
    .osc_fail_i (fail),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data)
  );

  typedef struct {
    logic [3:0] a;
    logic [7:0] d;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   pending = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 0;

  // monitor: state is stable between posedge+2 and the next posedge
  initial forever begin
    @(negedge clk);
    while (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      rd_addr = it.a;
      #1;
      total++;
      if (rd_data !== it.d) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, rd_data, it.d);
      end
      pending--;
    end
  end

  task automatic exp_reg(input logic [3:0] a, input logic [7:0] d, input string tag);
    sb_q.push_back('{a: a, d: d, tag: tag});
    pending++;
  endtask

  task automatic drain();
    wait (pending == 0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      tick = 1'b1;
      @(posedge clk); #2;
      tick = 1'b0;
    end
  endtask

  task automatic set_all(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] dt,
                         input logic [7:0] dw, input logic [7:0] h, input logic [7:0] mi,
                         input logic [7:0] s);
    wr(4'd6, y); wr(4'd5, mo); wr(4'd4, dt); wr(4'd3, dw);
    wr(4'd2, h); wr(4'd1, mi); wr(4'd0, s);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    rst_n = 1'b1;
    // R1 reset values
    exp_reg(0, 8'h00, "R1 sec"); exp_reg(1, 8'h00, "R1 min");
    exp_reg(2, 8'h00, "R1 hour"); exp_reg(3, 8'h01, "R1 dow");
    exp_reg(4, 8'h01, "R1 date"); exp_reg(5, 8'h01, "R1 mon");
    exp_reg(6, 8'h00, "R1 year"); exp_reg(7, 8'h80, "R1 flag");
    drain();

    // R2 prescaler counts enables only
    repeat (5) @(posedge clk);
    pulses(3); exp_reg(0, 8'h00, "R2 three enables"); drain();
    pulses(1); exp_reg(0, 8'h01, "R2 fourth enable"); drain();

    // R3 R4 R5 full cascade into March, non-leap year
    set_all(8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
    pulses(4);
    exp_reg(0, 8'h00, "R3 sec wrap"); exp_reg(1, 8'h00, "R3 min wrap");
    exp_reg(2, 8'h00, "R3 hour wrap"); exp_reg(3, 8'h01, "R4 dow wrap");
    drain();
    exp_reg(4, 8'h01, "R6 feb 28 nonleap"); exp_reg(5, 8'h03, "R6 mon march");
    exp_reg(6, 8'h23, "R7 year kept"); drain();

    // R6 leap year
    set_all(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    pulses(4);
    exp_reg(4, 8'h29, "R6 leap feb 29"); exp_reg(5, 8'h02, "R6 still feb");
    exp_reg(3, 8'h04, "R4 dow step"); drain();
    wr(4'd2, 8'h23); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    pulses(4);
    exp_reg(4, 8'h01, "R6 leap end"); exp_reg(5, 8'h03, "R6 leap march");
    exp_reg(3, 8'h05, "R4 dow step2"); drain();

    // R5 30 and 31 day months
    set_all(8'h24, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    pulses(4);
    exp_reg(4, 8'h01, "R5 april end"); exp_reg(5, 8'h05, "R5 may"); drain();
    set_all(8'h24, 8'h05, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    pulses(4);
    exp_reg(4, 8'h31, "R5 may 31"); exp_reg(5, 8'h05, "R5 still may"); drain();

    // R7 year wrap
    set_all(8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    pulses(4);
    exp_reg(6, 8'h00, "R7 year wrap"); exp_reg(5, 8'h01, "R7 mon wrap");
    exp_reg(4, 8'h01, "R7 date wrap"); drain();

    // R8 seconds write clears divider
    pulses(2);
    wr(4'd0, 8'h10);
    pulses(3); exp_reg(0, 8'h10, "R8 held after clear"); drain();
    pulses(1); exp_reg(0, 8'h11, "R8 full period"); drain();

    // R9 write wins over carry, written counter emits no carry
    wr(4'd2, 8'h10); wr(4'd0, 8'h59); wr(4'd1, 8'h59);
    pulses(3);
    @(posedge clk); #2;
    tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 8'h59;
    @(posedge clk); #2;
    tick = 1'b0; wr_en = 1'b0;
    exp_reg(0, 8'h00, "R9 sec wrapped"); exp_reg(1, 8'h59, "R9 min write wins");
    exp_reg(2, 8'h10, "R9 no hour carry"); drain();
    wr(4'd0, 8'h20);
    pulses(3);
    @(posedge clk); #2;
    tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'h59;
    @(posedge clk); #2;
    tick = 1'b0; wr_en = 1'b0;
    exp_reg(0, 8'h59, "R9 sec write wins"); exp_reg(1, 8'h59, "R9 no min carry"); drain();
    pulses(3); exp_reg(0, 8'h59, "R8 cleared by tick-cycle write"); drain();
    pulses(1);
    exp_reg(0, 8'h00, "R3 sec"); exp_reg(1, 8'h00, "R3 min");
    exp_reg(2, 8'h11, "R3 hour inc"); drain();

    // R10 oscillator-stop flag
    wr(4'd7, 8'hff); exp_reg(7, 8'h80, "R10 write one keeps"); drain();
    wr(4'd7, 8'h00); exp_reg(7, 8'h00, "R10 clear"); drain();
    wr(4'd7, 8'hff); exp_reg(7, 8'h00, "R10 no sw set"); drain();
    @(posedge clk); #2; fail = 1'b1;
    @(posedge clk); #2; fail = 1'b0;
    exp_reg(7, 8'h80, "R10 fail sets"); drain();
    @(posedge clk); #2;
    fail = 1'b1; wr_en = 1'b1; wr_addr = 4'd7; wr_data = 8'h00;
    @(posedge clk); #2;
    fail = 1'b0; wr_en = 1'b0;
    exp_reg(7, 8'h80, "R10 fail beats clear"); drain();

    // R11 field masks
    wr(4'd2, 8'hff); exp_reg(2, 8'h3f, "R11 hour mask"); drain();
    wr(4'd3, 8'hff); exp_reg(3, 8'h07, "R11 dow mask"); drain();
    wr(4'd5, 8'hff); exp_reg(5, 8'h1f, "R11 mon mask"); drain();

    // R12 unmapped addresses
    wr(4'd0, 8'h33);
    wr(4'd9, 8'h45);
    exp_reg(9, 8'h00, "R12 hole reads zero"); exp_reg(15, 8'h00, "R12 top hole");
    exp_reg(0, 8'h33, "R12 sec untouched"); exp_reg(1, 8'h00, "R12 min untouched");
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule